// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block produces the fetch address for a small processor whose program store holds 1K words and whose next word is fetched while the current one executes. It keeps a 13-bit counter. In a normal cycle the counter steps by one. On a jump or a call it takes a target address. A reset sends it to address 0000H, and an accepted interrupt sends it to 0004H. Call and interrupt return addresses are kept in a dedicated 8-entry, 13-bit hardware stack. Three return flavours (plain, from-interrupt, with-literal) pop that stack back into the counter.

Every change of flow makes the word already prefetched stale. The block then raises `flush` for one cycle. During that cycle the execute slot is empty: the block ignores the opcode and the interrupt request and simply steps the counter. Only the low 10 counter bits reach the program store. The upper 3 bits travel through the stack unchanged. The stack is circular, so a push beyond its depth silently overwrites the oldest entry.

Top module: `insn_addr_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `fetch_addr` is 000H, `flush` is 1 (the execute slot holds no word) and `gie_set` is 0.
- R2: In a cycle with `flush`=0, opcode none (code 0) and no interrupt request, the fetch address advances by one on the next edge, wraps from 3FFH to 000H, and `flush` stays 0.
- R3: A jump (code 5) loads the target address, so the next fetch address equals the low 10 bits of `tgt_addr`, and `flush` is 1 in the following cycle.
- R4: A call (code 1) loads the target like a jump and pushes the current counter, which is the address of the word after the call, onto the return stack.
- R5: A plain return (code 2), a return-from-interrupt (code 3) and a return-with-literal (code 4) each pop the stack into the counter in last-in first-out order and raise `flush` in the following cycle.
- R6: `gie_set` is 1 for exactly the one cycle after an executed return-from-interrupt, and is 0 after every other opcode.
- R7: A taken skip (code 6) advances the counter by one and raises `flush`, so the prefetched word is discarded.
- R8: An interrupt request in a cycle with `flush`=0 and opcode none pushes the current counter, loads 004H, and raises `flush` in the following cycle.
- R9: An interrupt request is ignored in a cycle that executes a change-of-flow opcode or that has `flush`=1.
- R10: In a cycle with `flush`=1 the opcode is ignored and the counter advances by one; `flush` is 0 in the cycle after.
- R11: The stack is circular with 8 entries: after nine pushes, pops return the last eight pushed addresses newest first, and a ninth pop returns the newest address again.
- R12: Opcode code 7 behaves exactly as opcode none, including interrupt acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one instruction cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request, already gated by the interrupt enable |
| op_kind | input | 3 | Flow class of the executing word: 0 none, 1 call, 2 return, 3 return-from-interrupt, 4 return-with-literal, 5 jump, 6 taken skip, 7 none |
| tgt_addr | input | 13 | Branch target for jump and call |
| fetch_addr | output | 10 | Program store address of the next fetch |
| flush | output | 1 | The word in the execute slot is stale and must be treated as empty |
| gie_set | output | 1 | One-cycle pulse that re-enables the global interrupt enable |

## Verification
The assertions assume that the surrounding decoder drives `op_kind` and `irq_req` as stable, defined values for the whole cycle. They also assume that push and pop requests never reach the stack together. The flow decoder guarantees the second point, and the stack checks it. The stimulus changes inputs only on the falling clock edge and always drives all three input groups. Returns are issued only after matching pushes, except in the deliberate wrap-around sequence, where every slot has been written before it is popped. No stack entry is read before it has been written.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   // flow class of the word in the execute slot
   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_CALL  = 3'd1,
      OP_RET   = 3'd2,
      OP_RETI  = 3'd3,
      OP_RETLW = 3'd4,
      OP_JUMP  = 3'd5,
      OP_SKIP  = 3'd6,
      OP_RSVD  = 3'd7
   } op_e;

   // source of the next counter value
   typedef enum logic [1:0] {
      NX_INC = 2'd0,
      NX_TGT = 2'd1,
      NX_POP = 2'd2,
      NX_VEC = 2'd3
   } nsel_e;

endpackage

// File: rtl/pcs_flow_ctl.sv
module pcs_flow_ctl
   import pcs_pkg::*;
(
   input  logic  bubble_i,
   input  op_e   op_i,
   input  logic  irq_i,
   output nsel_e sel_o,
   output logic  push_o,
   output logic  pop_o,
   output logic  redirect_o,
   output logic  gie_o
);

   always_comb begin
      sel_o      = NX_INC;
      push_o     = 1'b0;
      pop_o      = 1'b0;
      redirect_o = 1'b0;
      gie_o      = 1'b0;
      if (!bubble_i) begin
         unique case (op_i)
            OP_CALL: begin
               sel_o      = NX_TGT;
               push_o     = 1'b1;
               redirect_o = 1'b1;
            end
            OP_RET, OP_RETLW: begin
               sel_o      = NX_POP;
               pop_o      = 1'b1;
               redirect_o = 1'b1;
            end
            OP_RETI: begin
               sel_o      = NX_POP;
               pop_o      = 1'b1;
               redirect_o = 1'b1;
               gie_o      = 1'b1;
            end
            OP_JUMP: begin
               sel_o      = NX_TGT;
               redirect_o = 1'b1;
            end
            OP_SKIP: begin
               redirect_o = 1'b1;
            end
            OP_NONE, OP_RSVD: begin
               if (irq_i) begin
                  sel_o      = NX_VEC;
                  push_o     = 1'b1;
                  redirect_o = 1'b1;
               end
            end
            default: begin
               sel_o = NX_INC;
            end
         endcase
      end
   end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
   parameter int W     = 13,
   parameter int DEPTH = 8,
   parameter int STYLE = 0   // 0: indexed array with pointer, 1: rotating shift chain
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] push_d,
   output logic [W-1:0] top_o
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pcs_ret_stack: DEPTH must be a power of two of at least 2");
   end
   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("pcs_ret_stack: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_ptr
      localparam logic [PW-1:0] ONE_P = PW'(1);
      logic [PW-1:0] wp_q;
      logic [W-1:0]  mem [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      wp_q <= '0;
         else if (push_i) wp_q <= wp_q + ONE_P;
         else if (pop_i)  wp_q <= wp_q - ONE_P;
      end

      always_ff @(posedge clk) begin
         if (push_i) mem[wp_q] <= push_d;
      end

      assign top_o = mem[wp_q - ONE_P];
   end else begin : g_shift
      logic [W-1:0] sr [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
         end else if (push_i) begin
            sr[0] <= push_d;
            for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
         end else if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) sr[i] <= sr[i+1];
            sr[DEPTH-1] <= sr[0];
         end
      end

      assign top_o = sr[0];
   end

   // R5: the decoder never asks for a push and a pop in the same cycle
   p_push_pop_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));

   // R4: a pushed address is the one the next return will see
   p_top_after_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> top_o == $past(push_d));

endmodule

// File: rtl/insn_addr_seq.sv
module insn_addr_seq #(
   parameter int PC_W        = 13,
   parameter int FETCH_W     = 10,
   parameter int DEPTH       = 8,
   parameter int RESET_VEC   = 0,
   parameter int IRQ_VEC     = 4,
   parameter int STACK_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               irq_req,
   input  logic [2:0]         op_kind,
   input  logic [PC_W-1:0]    tgt_addr,
   output logic [FETCH_W-1:0] fetch_addr,
   output logic               flush,
   output logic               gie_set
);
   import pcs_pkg::*;

   localparam logic [PC_W-1:0]    RST_PC = PC_W'(RESET_VEC);
   localparam logic [PC_W-1:0]    IRQ_PC = PC_W'(IRQ_VEC);
   localparam logic [FETCH_W-1:0] ONE_F  = FETCH_W'(1);

   if (FETCH_W < 1 || FETCH_W > PC_W) begin : g_bad_width
      $error("insn_addr_seq: FETCH_W must lie in 1..PC_W");
   end
   if (IRQ_VEC < 0 || IRQ_VEC >= (1 << FETCH_W) ||
       RESET_VEC < 0 || RESET_VEC >= (1 << FETCH_W)) begin : g_bad_vec
      $error("insn_addr_seq: vectors must fit in the fetch address");
   end

   logic [PC_W-1:0] pc_q, pc_d, inc_pc, top_pc;
   logic            flush_q, gie_q;
   nsel_e           sel;
   logic            push, pop, redirect, gie_pulse;

   // step only the fetch field; any upper bits ride along untouched
   if (PC_W > FETCH_W) begin : g_inc_split
      assign inc_pc = {pc_q[PC_W-1:FETCH_W], pc_q[FETCH_W-1:0] + ONE_F};
   end else begin : g_inc_flat
      assign inc_pc = pc_q + ONE_F;
   end

   pcs_flow_ctl u_ctl (
      .bubble_i   (flush_q),
      .op_i       (op_e'(op_kind)),
      .irq_i      (irq_req),
      .sel_o      (sel),
      .push_o     (push),
      .pop_o      (pop),
      .redirect_o (redirect),
      .gie_o      (gie_pulse)
   );

   pcs_ret_stack #(
      .W     (PC_W),
      .DEPTH (DEPTH),
      .STYLE (STACK_STYLE)
   ) u_stk (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (push),
      .pop_i  (pop),
      .push_d (pc_q),
      .top_o  (top_pc)
   );

   always_comb begin
      unique case (sel)
         NX_TGT:  pc_d = tgt_addr;
         NX_POP:  pc_d = top_pc;
         NX_VEC:  pc_d = IRQ_PC;
         default: pc_d = inc_pc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= RST_PC;
         flush_q <= 1'b1;
         gie_q   <= 1'b0;
      end else begin
         pc_q    <= pc_d;
         flush_q <= redirect;
         gie_q   <= gie_pulse;
      end
   end

   assign fetch_addr = pc_q[FETCH_W-1:0];
   assign flush      = flush_q;
   assign gie_set    = gie_q;

   // R2: a quiet cycle steps the fetch address by one
   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && (op_kind == 3'd0) && !irq_req)
      |=> (fetch_addr == $past(fetch_addr) + ONE_F) && !flush);

   // R10: the empty slot after a redirect never redirects again
   p_bubble_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush && (fetch_addr == $past(fetch_addr) + ONE_F));

   // R3: a jump lands on its target
   p_jump_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && op_kind == 3'd5)
      |=> (fetch_addr == $past(tgt_addr[FETCH_W-1:0])) && flush);

   // R8: an accepted interrupt lands on the vector
   p_irq_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && op_kind == 3'd0 && irq_req)
      |=> (fetch_addr == IRQ_PC[FETCH_W-1:0]) && flush);

   // R6: the enable pulse follows only an executed return-from-interrupt
   p_gie_from_reti_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gie_set |-> $past(!flush && op_kind == 3'd3));

endmodule

// File: tb/sim_insn_addr_seq.sv
module sim_insn_addr_seq;

   localparam logic [2:0] C_NONE = 3'd0, C_CALL = 3'd1, C_RET = 3'd2,
                          C_RETI = 3'd3, C_RETLW = 3'd4, C_JUMP = 3'd5,
                          C_SKIP = 3'd6, C_RSVD = 3'd7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [2:0]  op_kind = 3'd0;
   logic [12:0] tgt_addr = '0;
   logic [9:0]  fetch_addr;
   logic        flush;
   logic        gie_set;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   insn_addr_seq u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_req    (irq_req),
      .op_kind    (op_kind),
      .tgt_addr   (tgt_addr),
      .fetch_addr (fetch_addr),
      .flush      (flush),
      .gie_set    (gie_set)
   );

   // reference state built from the requirements
   logic [12:0] m_pc;
   logic        m_flush;
   logic [12:0] m_stk [8];
   int          m_ptr;

   logic [11:0] qv [$];   // {flush, gie, fetch}
   string       qt [$];

   function automatic logic [12:0] m_inc(input logic [12:0] p);
      return {p[12:10], p[9:0] + 10'd1};
   endfunction

   task automatic compare(input string tag, input logic [11:0] exp_v);
      compared++;
      if ({flush, gie_set, fetch_addr} !== exp_v) begin
         mismatched++;
         $display("FAIL %s: fetch=%h flush=%b gie=%b expected fetch=%h flush=%b gie=%b",
                  tag, fetch_addr, flush, gie_set, exp_v[9:0], exp_v[11], exp_v[10]);
      end
   endtask

   // driver: apply inputs now, queue the expected result of the next edge
   task automatic step(input logic [2:0] op, input logic irq,
                       input logic [12:0] tgt, input string tag);
      logic [12:0] nxt;
      logic        nf, g;
      op_kind  = op;
      irq_req  = irq;
      tgt_addr = tgt;
      nf = 1'b0;
      g  = 1'b0;
      nxt = m_inc(m_pc);
      if (!m_flush) begin
         case (op)
            C_CALL: begin
               m_stk[m_ptr] = m_pc; m_ptr = (m_ptr + 1) % 8;
               nxt = tgt; nf = 1'b1;
            end
            C_RET, C_RETI, C_RETLW: begin
               m_ptr = (m_ptr + 7) % 8; nxt = m_stk[m_ptr];
               nf = 1'b1; g = (op == C_RETI);
            end
            C_JUMP: begin nxt = tgt; nf = 1'b1; end
            C_SKIP: begin nf = 1'b1; end
            default: begin
               if (irq) begin
                  m_stk[m_ptr] = m_pc; m_ptr = (m_ptr + 1) % 8;
                  nxt = 13'h0004; nf = 1'b1;
               end
            end
         endcase
      end
      m_pc = nxt;
      m_flush = nf;
      qv.push_back({nf, g, nxt[9:0]});
      qt.push_back(tag);
      @(negedge clk);
   endtask

   // monitor: compare one queued item per edge
   always @(posedge clk) begin
      #1;
      if (qv.size() > 0) begin
         logic [11:0] e;
         string t;
         e = qv.pop_front();
         t = qt.pop_front();
         compare(t, e);
      end
   end

   task automatic bubble(input string tag);
      step(C_NONE, 1'b0, 13'h0, tag);
   endtask

   initial begin
      m_pc = '0; m_flush = 1'b1; m_ptr = 0;
      for (int i = 0; i < 8; i++) m_stk[i] = '0;
      repeat (3) @(negedge clk);
      compare("R1 in reset", {1'b1, 1'b0, 10'h000});
      rst_n = 1'b1;
      #1;
      compare("R1 after release", {1'b1, 1'b0, 10'h000});

      step(C_JUMP, 1'b1, 13'h0123, "R10 R9 op and irq in empty slot");
      step(C_NONE, 1'b0, 13'h0, "R2");
      step(C_NONE, 1'b0, 13'h0, "R2");
      step(C_JUMP, 1'b0, 13'h1BFD, "R3 jump");
      bubble("R10");
      step(C_NONE, 1'b0, 13'h0, "R2");
      step(C_NONE, 1'b0, 13'h0, "R2 wrap");
      step(C_CALL, 1'b1, 13'h0040, "R9 R4 call beats irq");
      step(C_NONE, 1'b1, 13'h0, "R9 irq in empty slot");
      step(C_NONE, 1'b0, 13'h0, "R2");
      step(C_RET, 1'b0, 13'h0, "R5 plain return");
      bubble("R10");
      step(C_NONE, 1'b1, 13'h0, "R8 interrupt");
      bubble("R10");
      step(C_NONE, 1'b0, 13'h0, "R2");
      step(C_RETI, 1'b0, 13'h0, "R6 R5 return from interrupt");
      bubble("R6 pulse ends");
      step(C_SKIP, 1'b0, 13'h0, "R7 skip");
      bubble("R7");
      step(C_RSVD, 1'b0, 13'h0, "R12 code 7 steps");
      step(C_RSVD, 1'b1, 13'h0, "R12 code 7 takes irq");
      bubble("R10");
      step(C_CALL, 1'b0, 13'h0200, "R4 outer call");
      bubble("R10");
      step(C_CALL, 1'b0, 13'h0300, "R4 inner call");
      bubble("R10");
      step(C_RETLW, 1'b0, 13'h0, "R5 return with literal");
      bubble("R6 no pulse after literal return");
      step(C_RET, 1'b0, 13'h0, "R5 outer return");
      bubble("R10");
      for (int k = 0; k < 9; k++) begin
         step(C_CALL, 1'b0, 13'(13'h0010 + 13'(k * 16)), "R11 push");
         bubble("R11");
      end
      for (int k = 0; k < 9; k++) begin
         step(C_RET, 1'b0, 13'h0, "R11 pop");
         bubble("R11");
      end
      step(C_NONE, 1'b0, 13'h0, "R2");
      repeat (2) @(negedge clk);

      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule